// File: doc/BRIEF.md
# Access Cycle Timer

This block tracks how much master-clock time the processor bus consumes. Each accepted bus access carries a 24-bit address. The block classifies that address by bank (bits 23:16) and page (bits 15:8) into a fast, slow or extra-slow region. It then adds the matching cost to a running 64-bit master-clock count.

The video unit advances in fixed four-clock units. The block tracks the master-clock time that has not yet been handed to the video unit. While at least one full unit of it is outstanding, the block raises a single-cycle step pulse and retires that unit. It raises no more than one pulse per clock cycle. While any unit is outstanding the block lowers its ready output, so no new access can arrive until the video side has caught up.

Programmable fast-region selection does not exist here: every region that could be either fast or slow is charged the slow cost.

Top module: `access_cycle_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `mclk_count` is 0, `vstep` is 0 and `acc_ready` is 1.
- R2: An accepted access whose bank is 0x40 to 0x7F costs 8 master clocks, whatever its page.
- R3: An accepted access whose bank is 0xC0 to 0xFF costs 8 master clocks, whatever its page.
- R4: In banks 0x00 to 0x3F and 0x80 to 0xBF, pages 0x00 to 0x3F and 0x42 to 0x5F cost 6 master clocks.
- R5: In banks 0x00 to 0x3F and 0x80 to 0xBF, pages 0x40 and 0x41 cost 12 master clocks.
- R6: In banks 0x00 to 0x3F and 0x80 to 0xBF, pages 0x60 to 0xFF cost 8 master clocks.
- R7: An access is accepted on a rising edge where `acc_valid` and `acc_ready` are both 1. The cost of that access shows in `mclk_count` from that edge onward.
- R8: Each step pulse retires 4 master clocks. Once the block is ready again, the total number of pulses since reset equals `mclk_count` divided by 4, rounded down.
- R9: The step pulses that an access causes arrive one per cycle, in consecutive cycles, starting in the cycle right after the accepting edge. `acc_ready` is 0 in every cycle that carries a pulse.
- R10: `acc_valid` has no effect while `acc_ready` is 0: `mclk_count` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A bus access is presented |
| acc_addr | input | 24 | Address of the presented access |
| acc_ready | output | 1 | No video steps are outstanding, so an access can be taken |
| mclk_count | output | 64 | Accumulated master-clock count |
| vstep | output | 1 | One-cycle video step pulse, one per 4 master clocks |

## Verification
The assertions take two things for granted. First, reset is held for at least one rising edge before it is released. Second, the counter never wraps, so the difference between the master count and the stepped count stays below one step unit plus the largest cost. The stimulus holds reset for several edges and applies fewer than a hundred accesses, which keeps the count far from its 64-bit limit. To exercise R10, the bench keeps `acc_valid` asserted through the refused cycles that follow an extra-slow access; that access always leaves at least three steps outstanding, so the held strobe is never accepted.

// File: rtl/atm_pkg.sv
package atm_pkg;

    localparam int ATM_ADDR_W = 24;

    typedef enum logic [1:0] {
        RGN_FAST  = 2'd0,
        RGN_SLOW  = 2'd1,
        RGN_XSLOW = 2'd2
    } region_e;

    typedef struct packed {
        logic [7:0] bank;
        logic [7:0] page;
        logic [7:0] offs;
    } bus_addr_t;

    // Region of an address: bank ranges first, then page ranges.
    function automatic region_e classify(input bus_addr_t a);
        region_e r;
        if (a.bank[7:6] == 2'b01)        r = RGN_SLOW;   // banks 0x40..0x7F
        else if (a.bank[7:6] == 2'b11)   r = RGN_SLOW;   // banks 0xC0..0xFF
        else if (a.page[7])              r = RGN_SLOW;   // pages 0x80..0xFF
        else if (a.page[6:5] == 2'b11)   r = RGN_SLOW;   // pages 0x60..0x7F
        else if (a.page[7:1] == 7'h20)   r = RGN_XSLOW;  // pages 0x40..0x41
        else                             r = RGN_FAST;
        return r;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/atm_region_decode.sv
module atm_region_decode
    import atm_pkg::*;
#(
    parameter int FAST_COST  = 6,
    parameter int SLOW_COST  = 8,
    parameter int XSLOW_COST = 12,
    parameter int COST_W     = 4
) (
    input  logic [ATM_ADDR_W-1:0] addr,
    output logic [COST_W-1:0]     cost
);
    region_e rgn;

    always_comb begin
        rgn = classify(bus_addr_t'(addr));
        unique case (rgn)
            RGN_FAST:  cost = COST_W'(FAST_COST);
            RGN_XSLOW: cost = COST_W'(XSLOW_COST);
            default:   cost = COST_W'(SLOW_COST);
        endcase
    end
endmodule

// File: rtl/atm_master_counter.sv
module atm_master_counter #(
    parameter int CNT_W  = 64,
    parameter int COST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [COST_W-1:0] cost,
    output logic [CNT_W-1:0]  count
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)       count_q <= '0;
        else if (take) count_q <= count_q + CNT_W'(cost);
    end

    assign count = count_q;
endmodule

// File: rtl/atm_step_sequencer.sv
module atm_step_sequencer #(
    parameter int CNT_W     = 64,
    parameter int COST_W    = 4,
    parameter int STEP_UNIT = 4,
    parameter int RES_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [COST_W-1:0] cost,
    output logic              ready,
    output logic              step,
    output logic [CNT_W-1:0]  last_stepped
);
    localparam logic [RES_W-1:0] UNIT_R = RES_W'(STEP_UNIT);

    logic [RES_W-1:0] residue_q;
    logic [CNT_W-1:0] last_q;
    logic             owe;

    // Outstanding time is tracked in a narrow residue rather than by a
    // wide subtract of the two counters.
    assign owe = (residue_q >= UNIT_R);

    always_ff @(posedge clk) begin
        if (rst) begin
            residue_q <= '0;
            last_q    <= '0;
        end else if (owe) begin
            residue_q <= residue_q - UNIT_R;
            last_q    <= last_q + CNT_W'(STEP_UNIT);
        end else if (take) begin
            residue_q <= residue_q + RES_W'(cost);
        end
    end

    assign ready        = !owe;
    assign step         = owe;
    assign last_stepped = last_q;
endmodule

// File: rtl/access_cycle_timer.sv
module access_cycle_timer
    import atm_pkg::*;
#(
    parameter int CNT_W      = 64,
    parameter int FAST_COST  = 6,
    parameter int SLOW_COST  = 8,
    parameter int XSLOW_COST = 12,
    parameter int STEP_UNIT  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_valid,
    input  logic [ATM_ADDR_W-1:0] acc_addr,
    output logic                  acc_ready,
    output logic [CNT_W-1:0]      mclk_count,
    output logic                  vstep
);
    localparam int MAX_COST = max3(FAST_COST, SLOW_COST, XSLOW_COST);
    localparam int COST_W   = $clog2(MAX_COST + 1);
    localparam int RES_W    = $clog2(MAX_COST + STEP_UNIT);

    logic [COST_W-1:0] cost;
    logic              take;
    logic [CNT_W-1:0]  last_stepped;

    assign take = acc_valid && acc_ready;

    atm_region_decode #(
        .FAST_COST (FAST_COST),
        .SLOW_COST (SLOW_COST),
        .XSLOW_COST(XSLOW_COST),
        .COST_W    (COST_W)
    ) u_decode (
        .addr(acc_addr),
        .cost(cost)
    );

    atm_master_counter #(
        .CNT_W (CNT_W),
        .COST_W(COST_W)
    ) u_master (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .cost (cost),
        .count(mclk_count)
    );

    atm_step_sequencer #(
        .CNT_W    (CNT_W),
        .COST_W   (COST_W),
        .STEP_UNIT(STEP_UNIT),
        .RES_W    (RES_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .take        (take),
        .cost        (cost),
        .ready       (acc_ready),
        .step        (vstep),
        .last_stepped(last_stepped)
    );
endmodule

// File: rtl/atm_checker.sv
module atm_checker #(
    parameter int CNT_W      = 64,
    parameter int FAST_COST  = 6,
    parameter int SLOW_COST  = 8,
    parameter int XSLOW_COST = 12,
    parameter int STEP_UNIT  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic [23:0]      acc_addr,
    input logic             acc_ready,
    input logic [CNT_W-1:0] mclk,
    input logic             vstep,
    input logic [CNT_W-1:0] last
);
    logic       take;
    logic       low_bank;
    logic [7:0] pg;

    assign take     = acc_valid && acc_ready;
    assign low_bank = (acc_addr[23:22] == 2'b00) || (acc_addr[23:22] == 2'b10);
    assign pg       = acc_addr[15:8];

    // R1: counters cleared by reset
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (mclk == '0 && last == '0));

    // R2: banks 0x40..0x7F charge the slow cost
    p_slow_bank_r2: assert property (@(posedge clk) disable iff (rst)
        (take && acc_addr[23:22] == 2'b01) |=> (mclk - $past(mclk)) == CNT_W'(SLOW_COST));

    // R3: high banks charge the slow cost
    p_high_bank_r3: assert property (@(posedge clk) disable iff (rst)
        (take && acc_addr[23:22] == 2'b11) |=> (mclk - $past(mclk)) == CNT_W'(SLOW_COST));

    // R4: fast pages in the low banks
    p_fast_page_r4: assert property (@(posedge clk) disable iff (rst)
        (take && low_bank && (pg < 8'h40 || (pg >= 8'h42 && pg < 8'h60)))
        |=> (mclk - $past(mclk)) == CNT_W'(FAST_COST));

    // R5: extra-slow pages
    p_xslow_page_r5: assert property (@(posedge clk) disable iff (rst)
        (take && low_bank && (pg == 8'h40 || pg == 8'h41))
        |=> (mclk - $past(mclk)) == CNT_W'(XSLOW_COST));

    // R6: upper pages in the low banks
    p_slow_page_r6: assert property (@(posedge clk) disable iff (rst)
        (take && low_bank && pg >= 8'h60) |=> (mclk - $past(mclk)) == CNT_W'(SLOW_COST));

    // R10: no count change without an accepted access
    p_hold_count_r10: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(mclk));

    // R8: each pulse retires one unit, otherwise stepped count holds
    p_step_advance_r8: assert property (@(posedge clk) disable iff (rst)
        vstep |=> (last == $past(last) + CNT_W'(STEP_UNIT)));
    p_step_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !vstep |=> $stable(last));

    // R9: pulses only while not ready, and ready means caught up
    p_step_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
        vstep |-> !acc_ready);
    p_caught_up_r9: assert property (@(posedge clk) disable iff (rst)
        acc_ready |-> ((mclk - last) < CNT_W'(STEP_UNIT)));
endmodule

bind access_cycle_timer atm_checker #(
    .CNT_W     (CNT_W),
    .FAST_COST (FAST_COST),
    .SLOW_COST (SLOW_COST),
    .XSLOW_COST(XSLOW_COST),
    .STEP_UNIT (STEP_UNIT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .acc_valid(acc_valid),
    .acc_addr (acc_addr),
    .acc_ready(acc_ready),
    .mclk     (mclk_count),
    .vstep    (vstep),
    .last     (last_stepped)
);

// File: tb/access_cycle_timer_tb.sv
module access_cycle_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        acc_ready;
    logic [63:0] mclk_count;
    logic        vstep;

    typedef struct {
        logic [63:0] master;
        int          new_steps;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fails  = 0;
    logic [63:0] model_master = '0;
    int          steps_seen = 0;
    int          wait_cnt = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    access_cycle_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_ready (acc_ready),
        .mclk_count(mclk_count),
        .vstep     (vstep)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model_cost(input logic [23:0] a);
        logic [7:0] b;
        logic [7:0] p;
        b = a[23:16];
        p = a[15:8];
        if (b >= 8'h40 && b <= 8'h7F) return 8;   // R2
        if (b >= 8'hC0)               return 8;   // R3
        if (p == 8'h40 || p == 8'h41) return 12;  // R5
        if (p >= 8'h60)               return 8;   // R6
        return 6;                                 // R4
    endfunction

    task automatic push_expect(input logic [23:0] a, input string req);
        exp_t        e;
        logic [63:0] old;
        old          = model_master;
        model_master = model_master + 64'(model_cost(a));
        e.master     = model_master;
        e.new_steps  = int'(model_master / 4) - int'(old / 4);
        e.req        = req;
        sb_q.push_back(e);
    endtask

    task automatic drive(input logic [23:0] a, input string req);
        @(negedge clk);
        while (!acc_ready) @(negedge clk);
        acc_valid = 1'b1;
        acc_addr  = a;
        @(posedge clk);
        push_expect(a, req);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // R10: strobe held through refused cycles after an extra-slow access
    task automatic drive_stuffed(input logic [23:0] a, input logic [23:0] junk);
        @(negedge clk);
        while (!acc_ready) @(negedge clk);
        acc_valid = 1'b1;
        acc_addr  = a;
        @(posedge clk);
        push_expect(a, "R10");
        @(negedge clk);
        acc_addr = junk;
        @(negedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Monitor: counts pulses and compares with the scoreboard once ready
    always @(negedge clk) begin
        if (!rst) begin
            if (vstep) begin
                steps_seen++;
                wait_cnt++;
                chk(acc_ready == 1'b0, "R9", "ready during step", 64'(acc_ready), 64'd0);
            end
            if (sb_q.size() > 0 && acc_ready) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(mclk_count == e.master, e.req, "master count (R7)", mclk_count, e.master);
                chk(steps_seen == int'(e.master / 4), "R8", "total steps",
                    64'(steps_seen), e.master / 4);
                chk(wait_cnt == e.new_steps, "R9", "consecutive step cycles",
                    64'(wait_cnt), 64'(e.new_steps));
                wait_cnt = 0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mclk_count == 64'd0, "R1", "count in reset", mclk_count, 64'd0);
        chk(acc_ready == 1'b1, "R1", "ready in reset", 64'(acc_ready), 64'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(mclk_count == 64'd0, "R1", "count after reset", mclk_count, 64'd0);
        chk(vstep == 1'b0, "R1", "no step after reset", 64'(vstep), 64'd0);
        chk(acc_ready == 1'b1, "R1", "ready after reset", 64'(acc_ready), 64'd1);

        drive(24'h000000, "R4");
        drive(24'h001FFF, "R4");
        drive(24'h802000, "R4");
        drive(24'h3F3FFF, "R4");
        drive(24'h004200, "R4");
        drive(24'hBF5FFF, "R4");
        drive(24'h004000, "R5");
        drive(24'h8041FF, "R5");
        drive(24'hBF4100, "R5");
        drive(24'h006000, "R6");
        drive(24'h007FFF, "R6");
        drive(24'h808000, "R6");
        drive(24'h3FFFFF, "R6");
        drive(24'h400000, "R2");
        drive(24'h404000, "R2");
        drive(24'h7F2000, "R2");
        drive(24'hC00000, "R3");
        drive(24'hCF4100, "R3");
        drive(24'hFF1234, "R3");
        drive_stuffed(24'h004000, 24'h004100);
        drive_stuffed(24'h804100, 24'h000000);

        lfsr = 24'hACE1B5;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
            drive(lfsr, "R7");
        end

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        chk(mclk_count == model_master, "R7", "final count", mclk_count, model_master);
        chk(steps_seen == int'(model_master / 4), "R8", "final steps",
            64'(steps_seen), model_master / 4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule